// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive approximation converter and serves its result to a host processor. A one-cycle start request from the host, made while the block is idle, begins a conversion. For each bit, from the most significant down, the block drives a trial code to an external DAC and reads one comparator bit. It keeps the trial bit when the comparator reports that the analog input is at or above the DAC level, and clears it otherwise. Every conversion therefore lasts the same number of clocks, one per bit, whatever the input.

While it works, the block drops its status line. It also sends each decided bit on a serial output with a strobe, so a downstream receiver can take the code before the conversion is over. The finished code is held in a result register. The host reads that register a byte at a time through two read enables, while the next conversion is already running.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A `start_i` pulse while `eoc_o` is 1 begins a conversion. In the next cycle `eoc_o` is 0 and `dac_code_o` has only its top bit (bit N-1) set.
- R2: A conversion holds `eoc_o` at 0 for exactly N clock cycles (N = 12 by default), for any input value. `eoc_o` returns to 1 in the cycle after the last bit decision.
- R3: In the cycle where bit k is under trial, `dac_code_o` carries the bits already decided above k, a 1 at bit k, and zeros below k. At the next edge, bit k stays 1 if `cmp_i` is 1 (input at or above the DAC level) and becomes 0 otherwise. With an ideal comparator, the final code equals the input value.
- R4: `eoc_o` is 0 while a conversion is in progress and 1 at all other times.
- R5: A `start_i` pulse during a conversion is ignored. The bit sequence, the length and the result of the conversion in progress do not change.
- R6: The result register changes only when a conversion completes. During a following conversion it keeps the previous result.
- R7: In the cycle after each bit decision, `ser_vld_o` is 1 and `ser_bit_o` equals the decided bit. The bits come MSB first, N strobes per conversion. At other times `ser_vld_o` and `ser_bit_o` are 0.
- R8: With 8-bit bytes, `rd_hi_i` = 1 drives result bits N-1..8, zero-extended to 8 bits, on `rd_data_o`. `rd_lo_i` = 1 alone drives result bits 7..0. `rd_hi_i` takes priority when both are 1. With neither enable, `rd_data_o` is 0.
- R9: After reset, `eoc_o` is 1, `dac_code_o` is 0, the result is 0 and `ser_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request from the host |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | N | Trial code to the DAC |
| eoc_o | output | 1 | 0 while converting, 1 otherwise |
| ser_bit_o | output | 1 | Decided bit, MSB first |
| ser_vld_o | output | 1 | Strobe for `ser_bit_o` |
| rd_hi_i | input | 1 | High-byte read enable |
| rd_lo_i | input | 1 | Low-byte read enable |
| rd_data_o | output | BYTE_W | Selected result byte |

## Verification
The assertions assume that `start_i` is sampled synchronously and that `cmp_i` is a settled function of the current `dac_code_o`. They make no assumption about the order in which the host raises the read enables.

The bench meets these assumptions with an ideal comparator: a continuous integer comparison of a held input value against `dac_code_o`. It changes the input and all host controls only at falling edges, and changes the input only between conversions. Start pulses that land inside a conversion, read enables toggled mid-conversion, and the extreme codes (0, the full-scale code, and the codes either side of half scale) all stay within these assumptions.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int unsigned SAR_BYTE_W_DEF = 8;
   localparam int unsigned SAR_BITS_DEF   = 12;

   typedef enum logic [1:0] {
      RD_NONE = 2'b00,
      RD_LO   = 2'b01,
      RD_HI   = 2'b10,
      RD_BOTH = 2'b11
   } rd_sel_e;
endpackage

// File: rtl/sar_core.sv
module sar_core #(
   parameter int unsigned N = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic         cmp_i,
   output logic [N-1:0] dac_code_o,
   output logic         busy_o,
   output logic         done_o,
   output logic [N-1:0] fin_code_o,
   output logic         ser_bit_o,
   output logic         ser_vld_o
);
   localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

   logic [N-1:0] ptr_q;
   logic [N-1:0] code_q;
   logic [N-1:0] kept;
   logic         busy;

   assign busy       = |ptr_q;
   assign kept       = cmp_i ? code_q : (code_q & ~ptr_q);
   assign busy_o     = busy;
   assign done_o     = busy & ptr_q[0];
   assign fin_code_o = kept;
   assign dac_code_o = code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q     <= '0;
         code_q    <= '0;
         ser_bit_o <= 1'b0;
         ser_vld_o <= 1'b0;
      end else begin
         ser_vld_o <= busy;
         ser_bit_o <= busy & cmp_i;
         if (busy) begin
            ptr_q  <= ptr_q >> 1;
            code_q <= kept | (ptr_q >> 1);
         end else if (start_i) begin
            ptr_q  <= MSB_ONLY;
            code_q <= MSB_ONLY;
         end
      end
   end

   assert_ptr_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ptr_q));

   assert_first_trial_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy) |=> (busy && dac_code_o == MSB_ONLY));

   assert_no_early_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && !ptr_q[0]) |=> busy);

   assert_ignore_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && start_i) |=> (ptr_q == ($past(ptr_q) >> 1)));

   assert_serial_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_vld_o |-> $past(busy));
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port #(
   parameter int unsigned N      = 12,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              done_i,
   input  logic [N-1:0]      fin_code_i,
   input  logic              rd_hi_i,
   input  logic              rd_lo_i,
   output logic [BYTE_W-1:0] rd_data_o
);
   import sar_pkg::*;

   localparam int unsigned HI_W = N - BYTE_W;

   logic [N-1:0]      result_q;
   logic [BYTE_W-1:0] hi_byte;
   logic [BYTE_W-1:0] lo_byte;
   rd_sel_e           sel;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     result_q <= '0;
      else if (done_i) result_q <= fin_code_i;
   end

   assign lo_byte = result_q[BYTE_W-1:0];

   generate
      if (HI_W == BYTE_W) begin : g_hi_full
         assign hi_byte = result_q[N-1:BYTE_W];
      end else begin : g_hi_ext
         assign hi_byte = {{(BYTE_W-HI_W){1'b0}}, result_q[N-1:BYTE_W]};
      end
   endgenerate

   assign sel = rd_sel_e'({rd_hi_i, rd_lo_i});

   always_comb begin
      unique case (sel)
         RD_HI, RD_BOTH: rd_data_o = hi_byte;
         RD_LO:          rd_data_o = lo_byte;
         default:        rd_data_o = '0;
      endcase
   end

   assert_hold_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |=> $stable(result_q));

   assert_idle_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_hi_i && !rd_lo_i) |-> (rd_data_o == '0));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int unsigned N      = sar_pkg::SAR_BITS_DEF,
   parameter int unsigned BYTE_W = sar_pkg::SAR_BYTE_W_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              cmp_i,
   output logic [N-1:0]      dac_code_o,
   output logic              eoc_o,
   output logic              ser_bit_o,
   output logic              ser_vld_o,
   input  logic              rd_hi_i,
   input  logic              rd_lo_i,
   output logic [BYTE_W-1:0] rd_data_o
);
   generate
      if (N <= BYTE_W || N > 2 * BYTE_W) begin : g_bad_width
         $error("sar_conv_ctrl: N must lie in (BYTE_W, 2*BYTE_W]");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("sar_conv_ctrl: BYTE_W must be positive");
      end
   endgenerate

   logic         busy;
   logic         done;
   logic [N-1:0] fin_code;

   sar_core #(.N(N)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .cmp_i      (cmp_i),
      .dac_code_o (dac_code_o),
      .busy_o     (busy),
      .done_o     (done),
      .fin_code_o (fin_code),
      .ser_bit_o  (ser_bit_o),
      .ser_vld_o  (ser_vld_o)
   );

   sar_result_port #(.N(N), .BYTE_W(BYTE_W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (done),
      .fin_code_i (fin_code),
      .rd_hi_i    (rd_hi_i),
      .rd_lo_i    (rd_lo_i),
      .rd_data_o  (rd_data_o)
   );

   assign eoc_o = ~busy;

   assert_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoc_o && !start_i) |=> eoc_o);
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
   localparam int N  = 12;
   localparam int BW = 8;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          start = 0;
   logic          rd_hi = 0;
   logic          rd_lo = 0;
   logic          cmp;
   logic [N-1:0]  dac_code;
   logic          eoc, ser_bit, ser_vld;
   logic [BW-1:0] rd_data;
   int            vin = 0;

   int n_cmp = 0, n_bad = 0, cycles = 0;

   always #5 clk = ~clk;

   assign cmp = (vin >= int'(dac_code));

   sar_conv_ctrl #(.N(N), .BYTE_W(BW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
      .dac_code_o(dac_code), .eoc_o(eoc), .ser_bit_o(ser_bit),
      .ser_vld_o(ser_vld), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
      .rd_data_o(rd_data));

   // behavioural reference model
   int m_left = 0;  // bits still to decide
   int m_code = 0;
   int m_res  = 0;
   int m_sv   = 0;
   int m_sb   = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left = 0; m_code = 0; m_res = 0; m_sv = 0; m_sb = 0;
      end else if (m_left > 0) begin
         int pos;
         pos  = m_left - 1;
         m_sv = 1;
         m_sb = (vin >= m_code) ? 1 : 0;
         if (m_sb == 0) m_code = m_code & ~(1 << pos);
         if (pos > 0) m_code = m_code | (1 << (pos - 1));
         m_left = m_left - 1;
         if (m_left == 0) m_res = m_code;
      end else begin
         m_sv = 0; m_sb = 0;
         if (start) begin
            m_left = N;
            m_code = 1 << (N - 1);
         end
      end
   end

   function automatic int exp_rd();
      if (rd_hi) return (m_res >> BW) & ((1 << (N - BW)) - 1);
      if (rd_lo) return m_res & ((1 << BW) - 1);
      return 0;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      #2;
      if (!rst_n) begin
         chk("R9 eoc",  int'(eoc), 1);
         chk("R9 dac",  int'(dac_code), 0);
         chk("R9 sv",   int'(ser_vld), 0);
      end else begin
         chk("R4 R2 eoc", int'(eoc), (m_left > 0) ? 0 : 1);
         chk("R3 R1 dac", int'(dac_code), m_code);
         chk("R7 ser_vld", int'(ser_vld), m_sv);
         chk("R7 ser_bit", int'(ser_bit), m_sb);
         chk("R8 R6 rd_data", int'(rd_data), exp_rd());
      end
   end

   // explicit end-to-end result check through the byte port
   task automatic read_result(int v);
      @(negedge clk); rd_hi = 1; rd_lo = 0;
      @(negedge clk); chk("R3 hi byte", int'(rd_data), (v >> BW) & 15);
      rd_hi = 0; rd_lo = 1;
      @(negedge clk); chk("R3 lo byte", int'(rd_data), v & 255);
      rd_hi = 1; rd_lo = 1;
      @(negedge clk); chk("R8 both", int'(rd_data), (v >> BW) & 15);
      rd_hi = 0; rd_lo = 0;
      @(negedge clk); chk("R8 none", int'(rd_data), 0);
   endtask

   task automatic convert(int v, int extra_start_at, int rd_pat);
      int busy_cnt;
      @(negedge clk);
      vin = v; start = 1;
      @(negedge clk);
      start = 0;
      chk("R1 eoc low", int'(eoc), 0);
      chk("R1 msb trial", int'(dac_code), 1 << (N - 1));
      rd_hi = rd_pat[1]; rd_lo = rd_pat[0];
      busy_cnt = 0;
      for (int c = 0; c < N + 4; c++) begin
         if (eoc == 0) busy_cnt++;
         start = (c == extra_start_at);
         @(negedge clk);
      end
      start = 0; rd_hi = 0; rd_lo = 0;
      chk("R2 length", busy_cnt, N);
      chk("R5 R3 result", int'(dac_code), v);
      read_result(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      convert(0, -1, 0);
      convert(4095, -1, 1);
      convert(2048, 3, 2);
      convert(2047, 0, 3);
      convert(1365, 11, 1);
      convert(2748, 6, 2);
      convert(1, -1, 0);
      convert(3071, 5, 1);
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule